// File: doc/BRIEF.md
# Three-Way Global-History Branch Predictor

This block supplies several conditional-branch direction guesses per clock for a wide fetch front end. All guesses come from one shared global history register and one table of 2-bit saturating counters. The first guess reads the counter that the full history selects. Each later guess in the same cycle uses a shorter slice of the history to point at a group of neighbouring counters. The guesses already made in that cycle then choose one counter from the group. This keeps the whole chain inside one table read cycle, with no second pass through the table.

A fetch stage raises the predict strobe. One cycle later the block presents every guess and a count of how many are valid. The back end reports each resolved conditional branch through a valid/outcome pair. That report trains the counter the current history points at and shifts the outcome into the history.

Top module: `mbp_top`

## Requirements
- R1: On synchronous active-high reset every counter becomes 2'b01 (weakly not-taken), the history register becomes all zeros, and both outputs read zero.
- R2: A cycle with `predict_i` high makes `pred_count_o` equal NUM_PRED in the following cycle. A cycle with `predict_i` low makes `pred_count_o` and `pred_bits_o` zero in the following cycle.
- R3: `pred_bits_o[0]` is the upper bit of the counter at index H, where H is the full HIST_W-bit history.
- R4: `pred_bits_o[1]` is the upper bit of the counter at index {H[HIST_W-2:0], p0}, where p0 is the bit from R3. H[HIST_W-2:0] picks a pair of adjacent counters and p0 picks one of the pair.
- R5: `pred_bits_o[2]` is the upper bit of the counter at index {H[HIST_W-3:0], p0, p1}. The slice picks four adjacent counters, p0 is the more significant selector and p1 is the less significant one.
- R6: When `resolve_valid_i` is high, the counter at index H is incremented if `resolve_taken_i` is 1 and decremented if it is 0. The counter saturates at 3 and at 0.
- R7: When `resolve_valid_i` is high, the history shifts left by one and `resolve_taken_i` enters bit 0, so bit 0 always holds the newest outcome.
- R8: When predict and resolve occur in the same cycle, the guesses use the table and history as they were before that cycle's update.
- R9: A cycle with `resolve_valid_i` low leaves every counter and the history unchanged. Repeated predictions across such cycles return identical bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| predict_i | input | 1 | Request a set of guesses for the next cycle |
| resolve_valid_i | input | 1 | A resolved conditional branch is reported this cycle |
| resolve_taken_i | input | 1 | Outcome of that branch, 1 = taken |
| pred_bits_o | output | NUM_PRED | Guesses, bit 0 oldest branch in fetch order, 1 = taken |
| pred_count_o | output | $clog2(NUM_PRED+1) | Number of valid guesses in `pred_bits_o` |

## Verification
The bench targets the selection chain. A design that ordered p0 and p1 the wrong way in the third index, or that used the unshifted history for later guesses, would read the wrong neighbour and disagree with the reference once the counters diverge. Long taken and not-taken runs drive single counters into both saturation limits, where a wrapping counter would flip its guess. Cycles that both predict and resolve expose a design that forwards the fresh update into the guess. Idle stretches between two identical requests expose any drift of table or history when no branch resolves.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'b01;
    localparam ctr_t CTR_TOP  = 2'b11;
    localparam ctr_t CTR_BOT  = 2'b00;

    typedef struct packed {
        logic valid;
        logic taken;
    } outcome_t;

    // Saturating step of a 2-bit counter toward the observed direction.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == CTR_TOP) ? CTR_TOP : ctr_t'(cur + 2'd1);
        end else begin
            nxt = (cur == CTR_BOT) ? CTR_BOT : ctr_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

    // Direction carried by a counter: its upper bit.
    function automatic logic ctr_dir(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/mbp_history.sv
module mbp_history #(
    parameter int HIST_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  mbp_pkg::outcome_t     res_i,
    output logic [HIST_W-1:0]     hist_o
);
    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (res_i.valid) begin
            hist_q <= {hist_q[HIST_W-2:0], res_i.taken};
        end
    end

    assign hist_o = hist_q;
endmodule

// File: rtl/mbp_pht.sv
module mbp_pht #(
    parameter int HIST_W = 8,
    localparam int DEPTH = 1 << HIST_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  mbp_pkg::outcome_t            res_i,
    input  logic [HIST_W-1:0]            upd_idx_i,
    output mbp_pkg::ctr_t [DEPTH-1:0]    tab_o
);
    import mbp_pkg::*;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        ctr_t ctr_q;
        logic hit;

        assign hit = res_i.valid && (upd_idx_i == HIST_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctr_q <= CTR_INIT;
            end else if (hit) begin
                ctr_q <= ctr_step(ctr_q, res_i.taken);
            end
        end

        assign tab_o[e] = ctr_q;
    end
endmodule

// File: rtl/mbp_chain.sv
module mbp_chain #(
    parameter int HIST_W   = 8,
    parameter int NUM_PRED = 3,
    localparam int DEPTH   = 1 << HIST_W
) (
    input  logic [HIST_W-1:0]            hist_i,
    input  mbp_pkg::ctr_t [DEPTH-1:0]    tab_i,
    output logic [NUM_PRED-1:0]          pred_o
);
    import mbp_pkg::*;

    // Guess j reads index {hist[HIST_W-1-j:0], p0 .. p(j-1)}: the history
    // slice names a group of 2**j neighbours and earlier guesses pick one.
    always_comb begin
        logic [HIST_W-1:0] idx;
        logic              dir;
        idx    = hist_i;
        pred_o = '0;
        for (int j = 0; j < NUM_PRED; j++) begin
            dir       = ctr_dir(tab_i[idx]);
            pred_o[j] = dir;
            idx       = {idx[HIST_W-2:0], dir};
        end
    end
endmodule

// File: rtl/mbp_top.sv
module mbp_top #(
    parameter int HIST_W   = 8,
    parameter int NUM_PRED = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             predict_i,
    input  logic                             resolve_valid_i,
    input  logic                             resolve_taken_i,
    output logic [NUM_PRED-1:0]              pred_bits_o,
    output logic [$clog2(NUM_PRED+1)-1:0]    pred_count_o
);
    import mbp_pkg::*;

    localparam int DEPTH = 1 << HIST_W;
    localparam int CNT_W = $clog2(NUM_PRED + 1);

    outcome_t                res;
    logic [HIST_W-1:0]       hist_w;
    ctr_t [DEPTH-1:0]        ctr_tab;
    logic [NUM_PRED-1:0]     guess_w;
    logic [NUM_PRED-1:0]     bits_q;
    logic [CNT_W-1:0]        cnt_q;

    assign res.valid = resolve_valid_i;
    assign res.taken = resolve_taken_i;

    mbp_history #(.HIST_W(HIST_W)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .res_i  (res),
        .hist_o (hist_w)
    );

    mbp_pht #(.HIST_W(HIST_W)) u_pht (
        .clk       (clk),
        .rst       (rst),
        .res_i     (res),
        .upd_idx_i (hist_w),
        .tab_o     (ctr_tab)
    );

    mbp_chain #(.HIST_W(HIST_W), .NUM_PRED(NUM_PRED)) u_chain (
        .hist_i (hist_w),
        .tab_i  (ctr_tab),
        .pred_o (guess_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            cnt_q  <= '0;
        end else if (predict_i) begin
            bits_q <= guess_w;
            cnt_q  <= CNT_W'(NUM_PRED);
        end else begin
            bits_q <= '0;
            cnt_q  <= '0;
        end
    end

    assign pred_bits_o  = bits_q;
    assign pred_count_o = cnt_q;
endmodule

// File: rtl/mbp_checker.sv
module mbp_checker #(
    parameter int HIST_W   = 8,
    parameter int NUM_PRED = 3,
    localparam int DEPTH   = 1 << HIST_W
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             predict_i,
    input logic                             resolve_valid_i,
    input logic                             resolve_taken_i,
    input logic [HIST_W-1:0]                hist,
    input mbp_pkg::ctr_t [DEPTH-1:0]        tab,
    input logic [NUM_PRED-1:0]              pred_bits,
    input logic [$clog2(NUM_PRED+1)-1:0]    pred_count
);
    assert_count_R2: assert property (@(posedge clk) disable iff (rst)
        predict_i |=> pred_count == NUM_PRED);

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !predict_i |=> (pred_count == 0) && (pred_bits == '0));

    assert_primary_R3: assert property (@(posedge clk) disable iff (rst)
        predict_i |=> pred_bits[0] == $past(tab[hist][1]));

    assert_inc_R6: assert property (@(posedge clk) disable iff (rst)
        (resolve_valid_i && resolve_taken_i && tab[hist] != 2'b11)
        |=> tab[$past(hist)] == $past(tab[hist]) + 2'd1);

    assert_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
        (resolve_valid_i && resolve_taken_i && tab[hist] == 2'b11)
        |=> tab[$past(hist)] == 2'b11);

    assert_floor_R6: assert property (@(posedge clk) disable iff (rst)
        (resolve_valid_i && !resolve_taken_i && tab[hist] == 2'b00)
        |=> tab[$past(hist)] == 2'b00);

    assert_shift_R7: assert property (@(posedge clk) disable iff (rst)
        resolve_valid_i |=> (hist[0] == $past(resolve_taken_i))
                            && (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !resolve_valid_i |=> $stable(hist) && $stable(tab));
endmodule

bind mbp_top mbp_checker #(.HIST_W(HIST_W), .NUM_PRED(NUM_PRED)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .predict_i       (predict_i),
    .resolve_valid_i (resolve_valid_i),
    .resolve_taken_i (resolve_taken_i),
    .hist            (hist_w),
    .tab             (ctr_tab),
    .pred_bits       (pred_bits_o),
    .pred_count      (pred_count_o)
);

// File: tb/tb_mbp_top.sv
module tb_mbp_top;
    localparam int CLK_PERIOD = 10;
    localparam int HW         = 8;
    localparam int NP         = 3;
    localparam int DEPTH      = 1 << HW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          predict = 1'b0;
    logic          rv = 1'b0;
    logic          rt = 1'b0;
    logic [NP-1:0] bits;
    logic [1:0]    cnt;

    int checks = 0;
    int fails  = 0;
    int ref_tab[DEPTH];
    int ref_hist;
    int exp_bits;
    int exp_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbp_top #(.HIST_W(HW), .NUM_PRED(NP)) dut (
        .clk             (clk),
        .rst             (rst),
        .predict_i       (predict),
        .resolve_valid_i (rv),
        .resolve_taken_i (rt),
        .pred_bits_o     (bits),
        .pred_count_o    (cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference: guess j reads the counter at (history << j) with the
    // earlier guesses of the cycle filling the low j bits, p0 highest.
    function automatic int model_guess();
        int prefix = 0;
        int res = 0;
        for (int j = 0; j < NP; j++) begin
            int idx = ((ref_hist << j) | prefix) & (DEPTH - 1);
            int b = (ref_tab[idx] >= 2) ? 1 : 0;
            res = res | (b << j);
            prefix = (prefix << 1) | b;
        end
        return res;
    endfunction

    task automatic step(input logic p, input logic v, input logic t);
        predict = p;
        rv = v;
        rt = t;
        @(posedge clk);
        if (p) begin
            exp_bits = model_guess();
            exp_cnt = NP;
        end else begin
            exp_bits = 0;
            exp_cnt = 0;
        end
        if (v) begin
            if (t && ref_tab[ref_hist] < 3) ref_tab[ref_hist]++;
            if (!t && ref_tab[ref_hist] > 0) ref_tab[ref_hist]--;
            ref_hist = ((ref_hist << 1) | int'(t)) & (DEPTH - 1);
        end
        @(negedge clk);
        check("R2 count", int'(cnt), exp_cnt);
        check("R3 primary", int'(bits[0]), exp_bits & 1);
        check("R4 secondary", int'(bits[1]), (exp_bits >> 1) & 1);
        check("R5 third", int'(bits[2]), (exp_bits >> 2) & 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int saved;
        for (int i = 0; i < DEPTH; i++) ref_tab[i] = 1;
        ref_hist = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset count", int'(cnt), 0);
        check("R1 reset bits", int'(bits), 0);
        step(1'b1, 1'b0, 1'b0);
        check("R1 weak not-taken guesses", int'(bits), 0);

        // long taken run: counter at all-ones history saturates high
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        check("R6 saturate up", int'(bits[0]), 1);
        check("R7 history all ones", int'(bits), exp_bits);

        // long not-taken run: counter at zero history saturates low
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        check("R6 saturate down then climb", int'(bits), exp_bits);

        // alternating pattern trains neighbouring groups
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, logic'(i % 2));
        step(1'b1, 1'b0, 1'b0);
        check("R7 alternating history", int'(bits), exp_bits);
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, logic'((i % 3) != 0));
        step(1'b1, 1'b0, 1'b0);
        check("R5 pattern of three", int'(bits), exp_bits);

        // predict and resolve in the same cycle
        step(1'b1, 1'b1, 1'b1);
        check("R8 pre-update guesses", int'(bits), exp_bits);
        step(1'b1, 1'b1, 1'b0);
        check("R8 pre-update guesses", int'(bits), exp_bits);

        // idle cycles leave state alone
        step(1'b1, 1'b0, 1'b0);
        saved = int'(bits);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, logic'(i % 2));
        step(1'b1, 1'b0, 1'b1);
        check("R9 no change without resolve", int'(bits), saved);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic rp, rvv, rtt;
            rp  = logic'($urandom_range(0, 1));
            rvv = logic'($urandom_range(0, 3) != 0);
            rtt = logic'($urandom_range(0, 3) != 0);
            step(rp, rvv, rtt);
        end

        // reset mid-run restores initial state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) ref_tab[i] = 1;
        ref_hist = 0;
        step(1'b1, 1'b0, 1'b0);
        check("R1 re-reset guesses", int'(bits), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule